// File: doc/BRIEF.md
# MII Transmit Nibble Adapter

This block sits between a byte-wide transmit FIFO and a 4-bit MII transmit port. It runs entirely on the transmit clock that the PHY supplies. The FIFO side carries one byte at a time with valid, start-of-packet, end-of-packet and error markers. The adapter asserts its ready output on each cycle where it can take a byte. Each accepted byte goes out as two nibbles on consecutive clock cycles, low nibble first. The transmit-enable line frames the packet. All outputs are registered.

When any byte of a frame carries the error marker, the frame is still sent in full. The adapter raises the transmit-error line for one cycle inside that frame. After the final nibble of a frame, the enable line stays low for at least a configurable number of idle cycles before the next frame may start. A byte offered outside a frame without a start marker is taken and discarded. If the FIFO runs dry in the middle of a frame, the enable line drops until the next byte arrives.

Top module: `mii_tx_nibbler`

## Requirements
- R1: While reset is high, and on the first cycle after a reset edge, mii_txen and mii_txer are 0, mii_txd is 0 and in_ready is 0. After reset is released, in_ready is 1.
- R2: An accepted byte appears as two consecutive nibbles: bits [3:0] on the cycle after acceptance, then bits [7:4] on the cycle after that. When the FIFO keeps in_valid high, the bytes of a frame follow one another with no gap.
- R3: mii_txen is high on exactly the nibble cycles of a frame. When in_valid stays high throughout a frame, mii_txen forms one unbroken run of 2×(byte count) cycles.
- R4: Whenever mii_txen is 0, mii_txd is 0 and mii_txer is 0.
- R5: in_ready is high only when a byte can be taken: when idle, on the high-nibble cycle of a byte that is not the last byte of its frame, or on the final cycle of the minimum gap. It is never high while a low nibble is on the bus.
- R6: Between the last nibble of one frame and the first nibble of the next, mii_txen is low for at least GAP_CYC cycles. Back-to-back frames are separated by exactly GAP_CYC cycles.
- R7: If any byte of a frame has in_err set when it is accepted, mii_txer is high for exactly one cycle in that frame. That cycle is the low-nibble cycle of the first byte carrying the marker.
- R8: Error markers on later bytes of a frame that has already produced its error pulse produce no further pulse.
- R9: Outside a frame, a byte accepted without in_sop is discarded. mii_txen stays low and no nibble is produced for it.
- R10: A byte with both in_sop and in_eop set forms a complete frame of two nibble cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PHY transmit clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 2*NIB_W | Byte from the FIFO |
| in_valid | input | 1 | in_data and markers are valid |
| in_sop | input | 1 | Byte is the first of a frame |
| in_eop | input | 1 | Byte is the last of a frame |
| in_err | input | 1 | Frame is marked errored |
| in_ready | output | 1 | Adapter takes the byte at this edge if in_valid is high |
| mii_txd | output | NIB_W | Nibble toward the PHY |
| mii_txen | output | 1 | Transmit enable |
| mii_txer | output | 1 | Transmit error |

## Verification
On every cycle, the assertions check these properties:
- the quiet outputs during reset;
- zero data and no error while the enable line is low;
- an error pulse that lasts one cycle and falls inside the enable window;
- no enable pulse shorter than a full byte;
- no ready on the cycle after a byte is taken in the middle of a frame.

The following properties only show in the bench scenarios, which compare full nibble sequences against values computed from the stimulus:
- the low-then-high nibble order;
- the exact position of the error pulse;
- suppression of repeated error markers;
- discarding of bytes that arrive without a start marker;
- the exact minimum gap between back-to-back frames.

// File: rtl/mii_tx_pkg.sv
package mii_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2,
    ST_GAP  = 2'd3
  } tx_state_t;
endpackage

// File: rtl/mii_tx_seq.sv
module mii_tx_seq
  import mii_tx_pkg::*;
#(
  parameter int GAP_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_sop,
  input  logic in_eop,
  output logic in_ready,
  output logic load,
  output logic frame_start,
  output logic show_hi,
  output logic txen
);
  localparam int CW = (GAP_CYC < 2) ? 1 : $clog2(GAP_CYC + 1);
  localparam logic [CW-1:0] GAP_LAST = CW'(GAP_CYC - 1);

  tx_state_t state_q, state_d;
  logic in_frame_q, in_frame_d;
  logic last_q, last_d;
  logic [CW-1:0] gap_q, gap_d;
  logic rdy, take;

  always_comb begin
    rdy = 1'b0;
    case (state_q)
      ST_IDLE: rdy = 1'b1;
      ST_LO:   rdy = 1'b0;
      ST_HI:   rdy = !last_q;
      ST_GAP:  rdy = (gap_q == GAP_LAST);
      default: rdy = 1'b0;
    endcase
    if (rst) rdy = 1'b0;
  end

  assign take        = in_valid && rdy;
  assign load        = take && (in_frame_q || in_sop);
  assign frame_start = take && !in_frame_q && in_sop;
  assign in_ready    = rdy;
  assign show_hi     = (state_q == ST_LO);

  always_comb begin
    state_d    = state_q;
    in_frame_d = in_frame_q;
    last_d     = last_q;
    gap_d      = gap_q;
    case (state_q)
      ST_IDLE: begin
        if (load) begin
          state_d    = ST_LO;
          in_frame_d = 1'b1;
          last_d     = in_eop;
        end
      end
      ST_LO: state_d = ST_HI;
      ST_HI: begin
        if (last_q) begin
          state_d    = ST_GAP;
          in_frame_d = 1'b0;
          gap_d      = '0;
        end else if (load) begin
          state_d = ST_LO;
          last_d  = in_eop;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_GAP: begin
        if (load) begin
          state_d    = ST_LO;
          in_frame_d = 1'b1;
          last_d     = in_eop;
        end else if (rdy) begin
          state_d = ST_IDLE;
        end else begin
          gap_d = gap_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      in_frame_q <= 1'b0;
      last_q     <= 1'b0;
      gap_q      <= '0;
      txen       <= 1'b0;
    end else begin
      state_q    <= state_d;
      in_frame_q <= in_frame_d;
      last_q     <= last_d;
      gap_q      <= gap_d;
      txen       <= load || (state_q == ST_LO);
    end
  end

  // A low nibble is always followed by its high nibble
  AST_LO_THEN_HI: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LO) |=> (state_q == ST_HI && txen)) else $error("lo not followed by hi"); // R2
endmodule

// File: rtl/mii_tx_nibpath.sv
module mii_tx_nibpath #(
  parameter int NIB_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               show_hi,
  input  logic [2*NIB_W-1:0] byte_in,
  output logic [NIB_W-1:0]   txd
);
  logic [NIB_W-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      txd  <= '0;
      hi_q <= '0;
    end else if (load) begin
      txd  <= byte_in[NIB_W-1:0];
      hi_q <= byte_in[2*NIB_W-1:NIB_W];
    end else if (show_hi) begin
      txd <= hi_q;
    end else begin
      txd <= '0;
    end
  end
endmodule

// File: rtl/mii_tx_errmark.sv
module mii_tx_errmark (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic frame_start,
  input  logic err,
  output logic txer
);
  logic done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      txer   <= 1'b0;
    end else begin
      txer <= load && err && (frame_start || !done_q);
      if (frame_start)         done_q <= err;
      else if (load && err)    done_q <= 1'b1;
    end
  end

  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    txer |=> !txer) else $error("error pulse longer than one cycle"); // R7
endmodule

// File: rtl/mii_tx_nibbler.sv
module mii_tx_nibbler #(
  parameter int NIB_W   = 4,
  parameter int GAP_CYC = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2*NIB_W-1:0] in_data,
  input  logic               in_valid,
  input  logic               in_sop,
  input  logic               in_eop,
  input  logic               in_err,
  output logic               in_ready,
  output logic [NIB_W-1:0]   mii_txd,
  output logic               mii_txen,
  output logic               mii_txer
);
  logic load, frame_start, show_hi;

  mii_tx_seq #(.GAP_CYC(GAP_CYC)) i_seq (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_sop      (in_sop),
    .in_eop      (in_eop),
    .in_ready    (in_ready),
    .load        (load),
    .frame_start (frame_start),
    .show_hi     (show_hi),
    .txen        (mii_txen)
  );

  mii_tx_nibpath #(.NIB_W(NIB_W)) i_path (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .show_hi (show_hi),
    .byte_in (in_data),
    .txd     (mii_txd)
  );

  mii_tx_errmark i_err (
    .clk         (clk),
    .rst         (rst),
    .load        (load),
    .frame_start (frame_start),
    .err         (in_err),
    .txer        (mii_txer)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!mii_txen && !mii_txer && mii_txd == '0)) else $error("outputs active after reset"); // R1
  AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (rst)
    !mii_txen |-> (mii_txd == '0)) else $error("data nonzero while idle"); // R4
  AST_ERR_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    mii_txer |-> mii_txen) else $error("error outside frame"); // R7
  AST_ENABLE_FULL_BYTE: assert property (@(posedge clk) disable iff (rst)
    $rose(mii_txen) |=> mii_txen) else $error("enable shorter than a byte"); // R2
  AST_NO_READY_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
    (in_ready && in_valid && mii_txen) |=> !in_ready) else $error("ready during low nibble"); // R5
endmodule

// File: tb/test_mii_tx_nibbler.sv
module test_mii_tx_nibbler;
  localparam int NIB_W = 4;
  localparam int BW    = 2 * NIB_W;
  localparam int GAP   = 2;
  localparam int NV    = 6;
  // {byte count, first byte, error mask per byte}
  localparam logic [31:0] VEC [NV] = '{
    {8'd1, 8'hA5, 16'h0000},
    {8'd2, 8'h3C, 16'h0001},
    {8'd4, 8'h10, 16'h0008},
    {8'd8, 8'hF7, 16'h0000},
    {8'd3, 8'h81, 16'h0002},
    {8'd6, 8'h5E, 16'h0014}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1;
  logic [BW-1:0] in_data = '0;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_err = 1'b0;
  logic in_ready;
  logic [NIB_W-1:0] mii_txd;
  logic mii_txen, mii_txer;

  mii_tx_nibbler #(.NIB_W(NIB_W), .GAP_CYC(GAP)) i_mii_tx_nibbler (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .in_sop(in_sop), .in_eop(in_eop), .in_err(in_err), .in_ready(in_ready),
    .mii_txd(mii_txd), .mii_txen(mii_txen), .mii_txer(mii_txer)
  );

  int checks = 0, errors = 0;
  logic [NIB_W-1:0] mon_nib [0:127];
  int mon_cnt = 0, er_cnt = 0, er_idx = -1, runs = 0;
  int low_run = 0, last_gap = 0, frames_seen = 0;
  int r5_viol = 0, z_viol = 0, gap_viol = 0;
  logic prev_en = 1'b0;

  always @(posedge clk) begin
    #2;
    if (rst) begin
      prev_en = 1'b0;
      low_run = 0;
    end else if (mii_txen) begin
      if (!prev_en) begin
        runs++;
        last_gap = low_run;
        if (frames_seen > 0 && low_run < GAP) gap_viol++;
      end
      if (in_ready && (mon_cnt % 2 == 0)) r5_viol++;
      if (mii_txer) begin
        er_cnt++;
        if (er_idx < 0) er_idx = mon_cnt;
      end
      if (mon_cnt < 128) mon_nib[mon_cnt] = mii_txd;
      mon_cnt++;
      low_run = 0;
      prev_en = 1'b1;
    end else begin
      if (prev_en) frames_seen++;
      if (mii_txd != '0 || mii_txer) z_viol++;
      low_run++;
      prev_en = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    mon_cnt = 0; er_cnt = 0; er_idx = -1; runs = 0;
    r5_viol = 0; z_viol = 0; gap_viol = 0;
  endtask

  function automatic logic [BW-1:0] byte_of(input logic [BW-1:0] base, input int i);
    return base + BW'(i * 29);
  endfunction

  task automatic send_frame(input int n, input logic [BW-1:0] base, input logic [15:0] emask, input bit sop_on);
    for (int i = 0; i < n; i++) begin
      in_data  = byte_of(base, i);
      in_sop   = sop_on && (i == 0);
      in_eop   = (i == n - 1);
      in_err   = emask[i];
      in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_err = 1'b0;
  endtask

  task automatic check_frame(input int n, input logic [BW-1:0] base, input logic [15:0] emask, input int off);
    int bad = 0;
    int first = -1;
    for (int i = 0; i < n; i++) begin
      logic [BW-1:0] b = byte_of(base, i);
      if (mon_nib[off + 2*i]     != b[NIB_W-1:0])  bad++;
      if (mon_nib[off + 2*i + 1] != b[BW-1:NIB_W]) bad++;
      if (emask[i] && first < 0) first = i;
    end
    chk(bad == 0, "R2", "nibble mismatches", bad, 0);
    if (first >= 0)
      chk(er_idx == off + 2*first, "R7", "error pulse nibble index", er_idx, off + 2*first);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!mii_txen && !mii_txer, "R1", "enable/error in reset", {mii_txen, mii_txer}, 0);
    chk(mii_txd == '0, "R1", "data in reset", mii_txd, 0);
    chk(!in_ready, "R1", "ready in reset", in_ready, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready, "R1", "ready after reset", in_ready, 1);

    // table walk: R2 R3 R4 R5 R7 R8 R10
    for (int v = 0; v < NV; v++) begin
      int n = int'(VEC[v][31:24]);
      logic [BW-1:0] base = VEC[v][23:16];
      logic [15:0] em = VEC[v][15:0];
      clear_mon();
      send_frame(n, base, em, 1'b1);
      repeat (8) @(negedge clk);
      chk(mon_cnt == 2*n, (n == 1) ? "R10" : "R3", "enabled cycles", mon_cnt, 2*n);
      chk(runs == 1, "R3", "enable runs", runs, 1);
      check_frame(n, base, em, 0);
      chk(er_cnt == ((em != 0) ? 1 : 0), (em == 16'h0014) ? "R8" : "R7", "error pulses", er_cnt, (em != 0) ? 1 : 0);
      chk(r5_viol == 0, "R5", "ready on low nibble", r5_viol, 0);
      chk(z_viol == 0, "R4", "idle data/error", z_viol, 0);
    end

    // R9: byte without start marker outside a frame is dropped
    clear_mon();
    send_frame(1, 8'h77, 16'h0001, 1'b0);
    repeat (6) @(negedge clk);
    chk(mon_cnt == 0, "R9", "nibbles from dropped byte", mon_cnt, 0);
    chk(er_cnt == 0, "R9", "error from dropped byte", er_cnt, 0);

    // R6: back-to-back frames
    clear_mon();
    send_frame(3, 8'h42, 16'h0000, 1'b1);
    send_frame(2, 8'hC9, 16'h0002, 1'b1);
    repeat (8) @(negedge clk);
    chk(last_gap == GAP, "R6", "back-to-back gap", last_gap, GAP);
    chk(gap_viol == 0, "R6", "short gaps", gap_viol, 0);
    chk(runs == 2 && mon_cnt == 10, "R3", "runs*100+cycles", runs*100 + mon_cnt, 210);
    check_frame(3, 8'h42, 16'h0000, 0);
    check_frame(2, 8'hC9, 16'h0002, 6);

    // R1: reset in the middle of a frame
    in_data = 8'h5A; in_sop = 1'b1; in_valid = 1'b1;
    while (!mii_txen) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(!mii_txen && mii_txd == '0 && !mii_txer, "R1", "outputs after mid-frame reset", mii_txen, 0);
    in_valid = 1'b0; in_sop = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready && !mii_txen, "R1", "ready/idle after release", in_ready, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule